// File: doc/BRIEF.md
# I2C Target with Selectable Device Address

This block is a byte-oriented I2C target that connects an external two-wire bus to a 256-byte register memory inside the chip. A system clock much faster than SCL samples both bus lines through a two-flop synchronizer. Edge detection on the synchronized lines then finds START, repeated START and STOP conditions, and it finds the SCL edges that move data.

The address byte is matched against one of two values. One is the built-in default A2h. The other is a programmed byte supplied by the surrounding logic, and it takes effect only while the select input is high. A matching write sets a byte pointer from the second byte and stores the bytes that follow at that pointer. A matching read returns bytes from the current pointer for as long as the master acknowledges. The pointer steps after every byte moved and wraps from FFh to 00h. An address that does not match leaves the target silent until the next START. SDA is treated as open-drain: the block only ever pulls it low through an enable output.

Top module: `i2c_addr_target`

## Requirements
- R1: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. A repeated START in the middle of a transaction behaves exactly like a first START and returns the target to address reception.
- R2: With the select input low, an address byte whose upper seven bits equal those of A2h is acknowledged: SDA is held low through the 9th SCL pulse.
- R3: With the select input high, the match value is the programmed address byte and A2h is no longer acknowledged.
- R4: A non-matching address byte is not acknowledged. Every following byte up to the next START is left unacknowledged and does not alter memory.
- R5: In a write, the byte after the address byte loads the pointer, and each later byte is stored at the pointer. The target acknowledges every one of these bytes.
- R6: The pointer increments after every byte stored or sent and wraps from FFh to 00h.
- R7: A read that is not preceded by a pointer load starts at the current pointer value. Bytes keep coming while the master acknowledges (SDA low in the 9th bit).
- R8: After the master answers a read byte with NACK (SDA high in the 9th bit), the target leaves SDA released until the next START or STOP.
- R9: Transmitted bytes go most significant bit first. The SDA drive changes only while SCL is low and stays steady while SCL is high.
- R10: After reset, SDA is released, the pointer is 00h and every memory byte reads 00h.
- R11: Bit 0 of the address byte selects the direction: 0 means write and 1 means read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled SCL line |
| sdaIn | input | 1 | Sampled SDA line (wired-AND bus value) |
| addrSelect | input | 1 | High: match the programmed address; low: match A2h |
| progAddr | input | 8 | Programmed device address byte |
| sdaDriveLow | output | 1 | Pulls SDA low when high; SDA is released when low |

## Verification
The bench drives writes with several payloads and then reads them back: once with a pointer load and a repeated START, and once with no pointer load. This separates pointer loading from the pointer value that carries over from an earlier transaction. A burst that starts at FEh shows the wrap to 00h. A read taken right after reset tells cleared memory apart from stale data. A non-matching address followed by write bytes, then read back through a matching address, shows whether ignored traffic leaks into memory. Switching the select input shows that the default and programmed addresses exclude each other.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef struct packed {
    logic shiftIn;    // capture sampled SDA into the receive shifter
    logic takePtr;    // load pointer from the completed byte
    logic storeByte;  // write completed byte at pointer, then step pointer
    logic loadTx;     // fetch byte at pointer into transmit shifter, step pointer
    logic shiftTx;    // present the next transmit bit
  } ctrlStrobes_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_RACK_OK,
    ST_IGNORE
  } busState_e;

  typedef enum logic [1:0] {
    AF_PTR,
    AF_WDATA,
    AF_RDATA
  } afterAck_e;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  localparam int LINES = 2;

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prevQ;

  assign rawIn = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], rawIn[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '1;
    else       prevQ <= synced;
  end

  assign sclS     = synced[1];
  assign sdaS     = synced[0];
  assign sclRise  = sclS & ~prevQ[1];
  assign sclFall  = ~sclS & prevQ[1];
  assign startDet = sclS & prevQ[1] & prevQ[0] & ~sdaS;
  assign stopDet  = sclS & prevQ[1] & ~prevQ[0] & sdaS;

endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclRise,
  input  logic         sclFall,
  input  logic         sdaS,
  input  logic         startDet,
  input  logic         stopDet,
  input  logic         addrMatch,
  input  logic         rwBit,
  input  logic         txBit,
  output ctrlStrobes_t strb,
  output logic         sdaDriveLow
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

  busState_e        stateQ, stateD;
  afterAck_e        afterQ, afterD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             armedQ, armedD;

  always_comb begin
    stateD = stateQ;
    afterD = afterQ;
    cntD   = cntQ;
    armedD = armedQ;
    strb   = '0;
    if (stopDet) begin
      stateD = ST_IDLE;
      armedD = 1'b0;
    end else if (startDet) begin
      stateD = ST_ADDR;
      cntD   = '0;
      armedD = 1'b0;
    end else begin
      case (stateQ)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            cntD = cntQ + 1'b1;
            if (cntQ == BIT_LAST) begin
              cntD = '0;
              case (stateQ)
                ST_ADDR: begin
                  if (addrMatch) begin
                    stateD = ST_ACK;
                    afterD = rwBit ? AF_RDATA : AF_PTR;
                  end else begin
                    stateD = ST_IGNORE;
                  end
                end
                ST_PTR: begin
                  strb.takePtr = 1'b1;
                  stateD = ST_ACK;
                  afterD = AF_WDATA;
                end
                default: begin
                  strb.storeByte = 1'b1;
                  stateD = ST_ACK;
                  afterD = AF_WDATA;
                end
              endcase
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            if (!armedQ) begin
              armedD = 1'b1;
            end else begin
              armedD = 1'b0;
              cntD   = '0;
              case (afterQ)
                AF_PTR:   stateD = ST_PTR;
                AF_WDATA: stateD = ST_WDATA;
                default: begin
                  stateD = ST_RDATA;
                  strb.loadTx = 1'b1;
                end
              endcase
            end
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (cntQ == BIT_LAST) begin
              stateD = ST_RACK;
              cntD   = '0;
            end else begin
              strb.shiftTx = 1'b1;
              cntD = cntQ + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) stateD = sdaS ? ST_IGNORE : ST_RACK_OK;
        end
        ST_RACK_OK: begin
          if (sclFall) begin
            strb.loadTx = 1'b1;
            stateD = ST_RDATA;
            cntD   = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      afterQ <= AF_PTR;
      cntQ   <= '0;
      armedQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      afterQ <= afterD;
      cntQ   <= cntD;
      armedQ <= armedD;
    end
  end

  assign sdaDriveLow = ((stateQ == ST_ACK) && armedQ) ||
                       ((stateQ == ST_RDATA) && !txBit);

endmodule

// File: rtl/i2ct_datapath.sv
module i2ct_datapath
  import i2ct_pkg::*;
#(
  parameter int              DATA_W       = 8,
  parameter logic [DATA_W-1:0] DEFAULT_ADDR = 8'hA2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  ctrlStrobes_t      strb,
  input  logic              addrSelect,
  input  logic [DATA_W-1:0] progAddr,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              txBit,
  output logic [DATA_W-1:0] ptrQ
);

  localparam int DEPTH = 1 << DATA_W;

  logic [DATA_W-1:0] rxQ, rxNext, txQ, activeAddr;
  logic [DATA_W-1:0] mem [DEPTH];

  assign rxNext     = {rxQ[DATA_W-2:0], sdaS};
  assign activeAddr = addrSelect ? progAddr : DEFAULT_ADDR;
  assign addrMatch  = ((rxNext ^ activeAddr) >> 1) == '0;
  assign rwBit      = rxNext[0];
  assign txBit      = txQ[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxQ <= '0;
    end else if (strb.shiftIn) begin
      rxQ <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txQ <= '1;
    end else if (strb.loadTx) begin
      txQ <= mem[ptrQ];
    end else if (strb.shiftTx) begin
      txQ <= {txQ[DATA_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (strb.takePtr) begin
      ptrQ <= rxNext;
    end else if (strb.storeByte || strb.loadTx) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.storeByte) begin
      mem[ptrQ] <= rxNext;
    end
  end

endmodule

// File: rtl/i2c_addr_target.sv
module i2c_addr_target
  import i2ct_pkg::*;
#(
  parameter int              DATA_W       = 8,
  parameter logic [DATA_W-1:0] DEFAULT_ADDR = 8'hA2,
  parameter int              SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrSelect,
  input  logic [DATA_W-1:0] progAddr,
  output logic              sdaDriveLow
);

  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic addrMatch, rwBit, txBit;
  logic [DATA_W-1:0] ptrQ;
  ctrlStrobes_t strb;

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sclS     (sclS),
    .sdaS     (sdaS),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet)
  );

  i2ct_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sclRise     (sclRise),
    .sclFall     (sclFall),
    .sdaS        (sdaS),
    .startDet    (startDet),
    .stopDet     (stopDet),
    .addrMatch   (addrMatch),
    .rwBit       (rwBit),
    .txBit       (txBit),
    .strb        (strb),
    .sdaDriveLow (sdaDriveLow)
  );

  i2ct_datapath #(.DATA_W(DATA_W), .DEFAULT_ADDR(DEFAULT_ADDR)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sdaS       (sdaS),
    .strb       (strb),
    .addrSelect (addrSelect),
    .progAddr   (progAddr),
    .addrMatch  (addrMatch),
    .rwBit      (rwBit),
    .txBit      (txBit),
    .ptrQ       (ptrQ)
  );

endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker
  import i2ct_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclS,
  input logic              sdaDriveLow,
  input logic              startDet,
  input logic              stopDet,
  input ctrlStrobes_t      strb,
  input logic [DATA_W-1:0] ptrQ
);

  // R8: a STOP always leaves the line released
  p_release_on_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDriveLow);

  // R1: after a START the target is receiving the address, never driving
  p_start_releases_r1: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaDriveLow);

  // R9: the drive only moves while the synchronized SCL is low
  p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclS);

  // R6: every stored or sent byte advances the pointer by one, wrapping
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.storeByte || strb.loadTx) |=> ptrQ == DATA_W'($past(ptrQ) + 1'b1));

  // R5: pointer load, store and fetch never coincide
  p_one_action_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.takePtr, strb.storeByte, strb.loadTx}));

endmodule

bind i2c_addr_target i2ct_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sclS        (sclS),
  .sdaDriveLow (sdaDriveLow),
  .startDet    (startDet),
  .stopDet     (stopDet),
  .strb        (strb),
  .ptrQ        (ptrQ)
);

// File: tb/i2c_addr_target_tb.sv
`timescale 1ns/1ps
module i2c_addr_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 8 * CLK_PERIOD;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic addrSelect = 1'b0;
  logic [7:0] progAddr = 8'h00;
  logic sdaDriveLow;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaDriveLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_target u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclM),
    .sdaIn       (sdaLine),
    .addrSelect  (addrSelect),
    .progAddr    (progAddr),
    .sdaDriveLow (sdaDriveLow)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] gotByte;
  event       byteDone;

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finishTest();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // scoreboard monitor: compares each byte the target sends against the queue
  initial begin
    forever begin
      @(byteDone);
      if (expQ.size() == 0) begin
        check(1'b0, "SB_extra", gotByte, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(gotByte == e, t, gotByte, e);
      end
    end
  end

  task automatic pushExp(input logic [7:0] b, input string tag);
    expQ.push_back(b);
    tagQ.push_back(tag);
  endtask

  task automatic busStart();
    sdaM = 1'b1; #(QTR);
    sclM = 1'b1; #(QTR);
    sdaM = 1'b0; #(QTR);
    sclM = 1'b0; #(QTR);
  endtask

  task automatic busStop();
    sdaM = 1'b0; #(QTR);
    sclM = 1'b1; #(QTR);
    sdaM = 1'b1; #(QTR);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ackLine);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; #(QTR);
      sclM = 1'b1; #(QTR);
      #(QTR);
      sclM = 1'b0; #(QTR);
    end
    sdaM = 1'b1; #(QTR);
    sclM = 1'b1; #(QTR);
    ackLine = sdaLine;
    #(QTR);
    sclM = 1'b0; #(QTR);
  endtask

  task automatic readByte(input logic masterNack);
    logic [7:0] b;
    bit steady;
    steady = 1'b1;
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      logic early;
      #(QTR);
      sclM = 1'b1; #(QTR/2);
      early = sdaLine;
      #(QTR/2);
      b[i] = sdaLine;
      #(QTR - CLK_PERIOD);
      if (sdaLine !== early) steady = 1'b0;
      #(CLK_PERIOD);
      sclM = 1'b0; #(QTR);
    end
    check(steady, "R9_steady_high", {7'd0, steady}, 8'h01);
    gotByte = b;
    ->byteDone;
    sdaM = masterNack; #(QTR);
    sclM = 1'b1; #(2*QTR);
    sclM = 1'b0; #(QTR);
  endtask

  task automatic readN(input int n);
    for (int i = 0; i < n; i++) readByte(i == n - 1);
  endtask

  task automatic writeAck(input logic [7:0] b, input string tag);
    logic a;
    writeByte(b, a);
    check(a == 1'b0, tag, {7'd0, a}, 8'h00);
  endtask

  task automatic writeNack(input logic [7:0] b, input string tag);
    logic a;
    writeByte(b, a);
    check(a == 1'b1, tag, {7'd0, a}, 8'h01);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "WATCHDOG", 8'h00, 8'h01);
    finishTest();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1;
    check(sdaDriveLow == 1'b0, "R10_release", {7'd0, sdaDriveLow}, 8'h00);
    rstN = 1'b1;
    repeat (5) @(posedge clk);

    // R10: read straight after reset begins at pointer 00h with cleared memory
    busStart();
    writeAck(8'hA3, "R11_read_ack");
    pushExp(8'h00, "R10_mem0");
    pushExp(8'h00, "R10_mem1");
    readN(2);
    busStop();

    // R2, R5: default address write, pointer 10h, four bytes
    busStart();
    writeAck(8'hA2, "R2_default_ack");
    writeAck(8'h10, "R5_ptr_ack");
    writeAck(8'h11, "R5_data_ack");
    writeAck(8'h22, "R5_data_ack");
    writeAck(8'h33, "R5_data_ack");
    writeAck(8'h44, "R5_data_ack");
    busStop();

    // R1, R7, R8: pointer load, repeated START, sequential read ending in NACK
    busStart();
    writeAck(8'hA2, "R2_default_ack");
    writeAck(8'h10, "R5_ptr_ack");
    busStart();
    writeAck(8'hA3, "R1_rstart_ack");
    pushExp(8'h11, "R7_seq0");
    pushExp(8'h22, "R7_seq1");
    pushExp(8'h33, "R9_msb_first");
    readN(3);
    // an extra clock after the NACK: the line must stay released
    #(QTR);
    sclM = 1'b1; #(QTR);
    check(sdaLine == 1'b1, "R8_released", {7'd0, sdaLine}, 8'h01);
    #(QTR);
    sclM = 1'b0; #(QTR);
    check(sdaDriveLow == 1'b0, "R8_no_drive", {7'd0, sdaDriveLow}, 8'h00);
    busStop();

    // R7: read with no pointer load continues from the current pointer
    busStart();
    writeAck(8'hA3, "R11_read_ack");
    pushExp(8'h44, "R7_current_ptr");
    readN(1);
    busStop();

    // R6: burst across FFh wraps to 00h
    busStart();
    writeAck(8'hA2, "R6_addr");
    writeAck(8'hFE, "R6_ptr");
    writeAck(8'hAA, "R6_data");
    writeAck(8'hBB, "R6_data");
    writeAck(8'hCC, "R6_data");
    busStop();
    busStart();
    writeAck(8'hA2, "R6_addr");
    writeAck(8'hFE, "R6_ptr");
    busStart();
    writeAck(8'hA3, "R6_read");
    pushExp(8'hAA, "R6_fe");
    pushExp(8'hBB, "R6_ff");
    pushExp(8'hCC, "R6_wrap00");
    readN(3);
    busStop();

    // R4: unmatched address, then bytes that must be ignored
    busStart();
    writeNack(8'hA4, "R4_no_ack_addr");
    writeNack(8'h00, "R4_no_ack_byte");
    writeNack(8'h55, "R4_no_ack_byte");
    busStop();
    busStart();
    writeAck(8'hA2, "R4_addr");
    writeAck(8'h00, "R4_ptr");
    busStart();
    writeAck(8'hA3, "R4_read");
    pushExp(8'hCC, "R4_mem_unchanged");
    readN(1);
    busStop();

    // R3: programmed address replaces the default
    addrSelect = 1'b1;
    progAddr   = 8'h5C;
    busStart();
    writeNack(8'hA2, "R3_default_off");
    busStop();
    busStart();
    writeAck(8'h5C, "R3_prog_ack");
    writeAck(8'h20, "R3_ptr");
    writeAck(8'h77, "R3_data");
    busStop();
    busStart();
    writeAck(8'h5C, "R3_prog_ack");
    writeAck(8'h20, "R3_ptr");
    busStart();
    writeAck(8'h5D, "R3_prog_read");
    pushExp(8'h77, "R3_readback");
    readN(1);
    busStop();

    #(4*QTR);
    check(expQ.size() == 0, "SB_missing", 8'(expQ.size()), 8'h00);
    finishTest();
  end

endmodule